// File: doc/BRIEF.md
# Dual-Channel Pixel Stream Deinterleaver

This block sits behind the sample converters of a row-scanned image sensor. The sensor can drive one or two readout channels. In single-channel mode every column of a row arrives on channel A, one per sample strobe. In dual-channel mode each strobe carries a column pair: channel A holds the odd column and channel B the even column that follows it. The block rebuilds one raster-ordered pixel stream from these samples, one pixel per clock. Each pixel carries a start-of-line mark, an end-of-line mark and a start-of-frame mark.

A level indicator from the sensor travels with the samples. While it is high, the samples are image data. While it is low, the sensor is between rows and channel A carries the on-die temperature reading. The block keeps the last such reading in a registered temperature word.

It also checks each row against the configured active width. A row that is too long or too short raises a one-cycle error pulse, and the block realigns at the start of the next row. A start-of-line arriving after the configured number of rows, with no new frame start in between, raises the same pulse. The widths default to a 640 by 480 format, so reduced windows such as 384 by 288 or 320 by 240 are set at run time through the width and height inputs.

Top module: `raster_deinterleave`

## Requirements
- R1: While reset is high and on the first falling edge after it, `pix_valid_o`, `sol_o`, `eol_o`, `sof_o` and `line_err_o` are 0, and `pix_o` and `temp_o` are 0.
- R2: With `dual_mode_i`=0, each accepted strobe emits exactly one pixel, equal to `chan_a_i`, in the cycle after the strobe edge. `chan_b_i` has no effect on the stream.
- R3: With `dual_mode_i`=1, each accepted strobe emits `chan_a_i` in the cycle after the strobe edge and `chan_b_i` in the cycle after that. Strobes are at least two cycles apart and the width is even.
- R4: Only a cycle with `smp_stb_i`=1 and `vid_valid_i`=1 yields pixels. A strobe with `vid_valid_i`=0 emits nothing, and `vid_valid_i` is ignored in cycles without a strobe.
- R5: At the first strobe with `vid_valid_i`=1 that follows one or more strobes with `vid_valid_i`=0, `temp_o` takes the `chan_a_i` value of the last of those low strobes. The new value is visible in the next cycle. At all other times `temp_o` holds, and `chan_b_i` never reaches it.
- R6: A row starts at the first strobe with `vid_valid_i`=1 after a strobe with it at 0, or after reset. `sol_o` marks pixel index 0 of the row, and `eol_o` marks pixel index `cfg_width_i`-1.
- R7: `sof_o` is set on the first pixel emitted after a one-cycle `frame_start_i` pulse and on no later pixel until the next pulse.
- R8: A valid strobe that arrives when `cfg_width_i` pixels of the row have already been emitted pulses `line_err_o` for one cycle after it. That strobe and all later strobes are dropped until the next row start.
- R9: The first strobe with `vid_valid_i`=0 after a row that emitted fewer than `cfg_width_i` pixels pulses `line_err_o` in the next cycle.
- R10: A row start after `cfg_height_i` rows have been counted since the last `frame_start_i` (or reset) pulses `line_err_o` in the next cycle. That row is still emitted.
- R11: A full 640-pixel row is carried with correct order and marks in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | One-cycle pulse that arms start-of-frame and clears the row count |
| smp_stb_i | input | 1 | Sample strobe for both channels |
| chan_a_i | input | DW | Channel A sample (all columns, or odd columns in dual mode) |
| chan_b_i | input | DW | Channel B sample (even columns in dual mode) |
| vid_valid_i | input | 1 | 1 = image data, 0 = temperature level |
| dual_mode_i | input | 1 | 1 = two channels, 0 = channel A only |
| cfg_width_i | input | $clog2(MAX_W+1) | Active pixels per row |
| cfg_height_i | input | $clog2(MAX_H+1) | Active rows per frame |
| pix_o | output | DW | Output pixel |
| pix_valid_o | output | 1 | Output pixel qualifier |
| sol_o | output | 1 | First pixel of a row |
| eol_o | output | 1 | Last pixel of a row |
| sof_o | output | 1 | First pixel after a frame start |
| temp_o | output | DW | Registered temperature word |
| line_err_o | output | 1 | One-cycle row width or row count error |

## Verification
Every result is due at a fixed distance from the strobe edge that causes it. The channel-A pixel, the error pulse and the temperature update all appear one cycle after that edge, and the channel-B pixel appears two cycles after it. The bench drives a strobe on a falling edge and reads the error and temperature on the next falling edge. A falling-edge monitor compares each pixel, with its marks, in order against an expected queue that is filled when the stimulus is issued. Any pixel that arrives with nothing expected, or an expected pixel left over at the end, counts as a mismatch.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef struct packed {
    logic sof;
    logic sol;
    logic eol;
  } mark_t;
endpackage

// File: rtl/line_tracker.sv
module line_tracker
  import raster_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_i,
  input  logic          vld_i,
  input  logic          dual_i,
  input  logic          fs_i,
  input  logic [XW-1:0] width_i,
  input  logic [YW-1:0] height_i,
  output logic          acc_o,
  output logic          rise_o,
  output mark_t         a_mark_o,
  output logic          b_eol_o,
  output logic          err_o
);
  localparam int CW = XW + 1;

  logic [CW-1:0] col, col_eff, wid, step;
  logic [YW:0]   row;
  logic          prev_vld, dropping, drop_eff;
  logic          fall, over, short_ln, row_over;

  always_comb begin
    wid      = CW'(width_i);
    step     = dual_i ? CW'(2) : CW'(1);
    rise_o   = stb_i & vld_i & ~prev_vld;
    fall     = stb_i & ~vld_i & prev_vld;
    col_eff  = rise_o ? '0 : col;
    drop_eff = rise_o ? 1'b0 : dropping;
    over     = stb_i & vld_i & ~drop_eff & (col_eff >= wid);
    acc_o    = stb_i & vld_i & ~drop_eff & ~over;
    short_ln = fall & ~dropping & (col != wid);
    row_over = rise_o & ~fs_i & (row >= (YW+1)'(height_i));
    a_mark_o.sof = 1'b0;
    a_mark_o.sol = (col_eff == '0);
    a_mark_o.eol = ~dual_i & (col_eff + CW'(1) == wid);
    b_eol_o      = dual_i & (col_eff + CW'(2) == wid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col      <= '0;
      row      <= '0;
      prev_vld <= 1'b0;
      dropping <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      err_o <= over | short_ln | row_over;
      if (stb_i) begin
        prev_vld <= vld_i;
        dropping <= over | drop_eff;
      end
      if (acc_o)
        col <= col_eff + step;
      else if (rise_o)
        col <= '0;
      if (fs_i)
        row <= rise_o ? (YW+1)'(1) : '0;
      else if (rise_o && !row_over)
        row <= row + (YW+1)'(1);
    end
  end

  // R8: once a row has overrun, no strobe is accepted until a new row begins
  p_drop_hold_r8: assert property (@(posedge clk) disable iff (rst)
    over |=> (acc_o ? rise_o : 1'b1));
endmodule

// File: rtl/temp_sampler.sv
module temp_sampler #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_i,
  input  logic          vld_i,
  input  logic          rise_i,
  input  logic [DW-1:0] lane_i,
  output logic [DW-1:0] temp_o
);
  logic [DW-1:0] cand;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand   <= '0;
      seen   <= 1'b0;
      temp_o <= '0;
    end else begin
      if (stb_i && !vld_i) begin
        cand <= lane_i;
        seen <= 1'b1;
      end
      if (rise_i && seen) begin
        temp_o <= cand;
        seen   <= 1'b0;
      end
    end
  end

  // R5: the temperature word moves only at a row start
  p_temp_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rise_i |=> $stable(temp_o));
endmodule

// File: rtl/pair_serializer.sv
module pair_serializer
  import raster_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_i,
  input  logic          dual_i,
  input  logic          fs_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  mark_t         a_mark_i,
  input  logic          b_eol_i,
  output logic [DW-1:0] pix_o,
  output logic          valid_o,
  output mark_t         mark_o
);
  logic [DW-1:0] b_hold;
  logic          b_eol_hold, b_pend, sof_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_o      <= '0;
      valid_o    <= 1'b0;
      mark_o     <= '0;
      b_hold     <= '0;
      b_eol_hold <= 1'b0;
      b_pend     <= 1'b0;
      sof_pend   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      mark_o  <= '0;
      if (acc_i) begin
        pix_o       <= a_i;
        valid_o     <= 1'b1;
        mark_o.sol  <= a_mark_i.sol;
        mark_o.eol  <= a_mark_i.eol;
        mark_o.sof  <= sof_pend | fs_i;
        b_hold      <= b_i;
        b_eol_hold  <= b_eol_i;
        b_pend      <= dual_i;
        sof_pend    <= 1'b0;
      end else begin
        if (fs_i)
          sof_pend <= 1'b1;
        if (b_pend) begin
          pix_o      <= b_hold;
          valid_o    <= 1'b1;
          mark_o.eol <= b_eol_hold;
          b_pend     <= 1'b0;
        end
      end
    end
  end

  // R3: a column pair is never overrun by the next strobe
  p_pair_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    b_pend |-> !acc_i);
  // R6: row and frame marks only ride on valid pixels
  p_marks_need_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (mark_o.sol || mark_o.eol || mark_o.sof) |-> valid_o);
endmodule

// File: rtl/raster_deinterleave.sv
module raster_deinterleave
  import raster_pkg::*;
#(
  parameter int DW    = 14,
  parameter int MAX_W = 640,
  parameter int MAX_H = 480,
  localparam int XW   = $clog2(MAX_W + 1),
  localparam int YW   = $clog2(MAX_H + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start_i,
  input  logic          smp_stb_i,
  input  logic [DW-1:0] chan_a_i,
  input  logic [DW-1:0] chan_b_i,
  input  logic          vid_valid_i,
  input  logic          dual_mode_i,
  input  logic [XW-1:0] cfg_width_i,
  input  logic [YW-1:0] cfg_height_i,
  output logic [DW-1:0] pix_o,
  output logic          pix_valid_o,
  output logic          sol_o,
  output logic          eol_o,
  output logic          sof_o,
  output logic [DW-1:0] temp_o,
  output logic          line_err_o
);
  logic  acc, rise, b_eol;
  mark_t a_mark, out_mark;

  line_tracker #(.XW(XW), .YW(YW)) u_track (
    .clk(clk), .rst(rst), .stb_i(smp_stb_i), .vld_i(vid_valid_i),
    .dual_i(dual_mode_i), .fs_i(frame_start_i), .width_i(cfg_width_i),
    .height_i(cfg_height_i), .acc_o(acc), .rise_o(rise),
    .a_mark_o(a_mark), .b_eol_o(b_eol), .err_o(line_err_o)
  );

  temp_sampler #(.DW(DW)) u_temp (
    .clk(clk), .rst(rst), .stb_i(smp_stb_i), .vld_i(vid_valid_i),
    .rise_i(rise), .lane_i(chan_a_i), .temp_o(temp_o)
  );

  pair_serializer #(.DW(DW)) u_ser (
    .clk(clk), .rst(rst), .acc_i(acc), .dual_i(dual_mode_i),
    .fs_i(frame_start_i), .a_i(chan_a_i), .b_i(chan_b_i),
    .a_mark_i(a_mark), .b_eol_i(b_eol), .pix_o(pix_o),
    .valid_o(pix_valid_o), .mark_o(out_mark)
  );

  assign sol_o = out_mark.sol;
  assign eol_o = out_mark.eol;
  assign sof_o = out_mark.sof;

  // R4: every output pixel traces back to a valid strobe one or two cycles earlier
  p_no_pix_without_stb_r4: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o |-> ($past(smp_stb_i && vid_valid_i) || $past(smp_stb_i && vid_valid_i, 2)));
endmodule

// File: tb/raster_deinterleave_test.sv
module raster_deinterleave_test;
  localparam int DW = 14;
  localparam int XW = $clog2(641);
  localparam int YW = $clog2(481);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fs = 1'b0, stb = 1'b0, vv = 1'b0, dual = 1'b0;
  logic [DW-1:0] ca = '0, cb = '0;
  logic [XW-1:0] wid = '0;
  logic [YW-1:0] hgt = '0;
  logic [DW-1:0] pix, temp;
  logic pv, sol, eol, sof, err;

  always #10 clk = ~clk;

  raster_deinterleave uut (
    .clk(clk), .rst(rst), .frame_start_i(fs), .smp_stb_i(stb),
    .chan_a_i(ca), .chan_b_i(cb), .vid_valid_i(vv), .dual_mode_i(dual),
    .cfg_width_i(wid), .cfg_height_i(hgt), .pix_o(pix), .pix_valid_o(pv),
    .sol_o(sol), .eol_o(eol), .sof_o(sof), .temp_o(temp), .line_err_o(err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DW+2:0] expq[$];
  int W, H, rows;
  bit sof_armed = 1'b0, short_pend = 1'b0;
  logic [DW-1:0] exp_temp = '0;
  logic err_s;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pv_of(int row, int col);
    return DW'(row * 37 + col * 3 + 5);
  endfunction

  always @(negedge clk) begin
    if (!rst && pv) begin
      if (expq.size() == 0)
        chk(1'b0, "R4 unexpected pixel", {sof, sol, eol, pix}, 0);
      else begin
        logic [DW+2:0] e;
        e = expq.pop_front();
        chk({sof, sol, eol, pix} == e, "R2 R3 R6 R7 R11 pixel stream",
            {sof, sol, eol, pix}, e);
      end
    end
  end

  task automatic strobe(logic [DW-1:0] a, logic [DW-1:0] b, logic v);
    @(negedge clk);
    stb = 1'b1; ca = a; cb = b; vv = v;
    @(negedge clk);
    stb = 1'b0; vv = ~v; ca = ~a; cb = ~b;
    err_s = err;
  endtask

  task automatic pulse_fs();
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
    sof_armed = 1'b1;
    rows = 0;
  endtask

  task automatic send_gap(int n, int base);
    logic [DW-1:0] old;
    old = exp_temp;
    for (int k = 0; k < n; k++) begin
      strobe(DW'(base + k), DW'(base + 77 + k), 1'b0);
      if (k == 0) chk(err_s == short_pend, "R9 short row error", err_s, short_pend);
      else chk(err_s == 1'b0, "R9 no error in gap", err_s, 0);
      short_pend = 1'b0;
    end
    chk(temp == old, "R5 temp holds during gap", temp, old);
    exp_temp = DW'(base + n - 1);
  endtask

  task automatic send_line(int npix, int tag);
    int nstb;
    bit over_seen, row_err, exp_err;
    nstb = dual ? npix / 2 : npix;
    over_seen = 1'b0;
    row_err = (rows >= H);
    for (int s = 0; s < nstb; s++) begin
      int c0;
      logic [DW-1:0] bval;
      c0 = dual ? 2 * s : s;
      bval = dual ? pv_of(tag, c0 + 1) : DW'(16'h2AAA ^ s);
      if (c0 < W) begin
        expq.push_back({sof_armed, c0 == 0, !dual && c0 == W - 1, pv_of(tag, c0)});
        sof_armed = 1'b0;
        if (dual) expq.push_back({1'b0, 1'b0, c0 + 1 == W - 1, bval});
      end
      exp_err = (s == 0 && row_err) || (c0 >= W && !over_seen);
      if (c0 >= W) over_seen = 1'b1;
      strobe(pv_of(tag, c0), bval, 1'b1);
      chk(err_s == exp_err, "R8 R10 row error pulse", err_s, exp_err);
      if (s == 0) chk(temp == exp_temp, "R5 temp update at row start", temp, exp_temp);
    end
    chk(temp == exp_temp, "R5 temp holds in row", temp, exp_temp);
    rows++;
    short_pend = (npix < W);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    rows = 0;
    repeat (3) @(posedge clk);
    chk(!pv && !sol && !eol && !sof && !err, "R1 flags in reset", {pv, sol, eol, sof, err}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(pix == '0 && temp == '0 && !pv, "R1 reset state", {pix, temp, pv}, 0);

    // single channel, width 8, height 3
    W = 8; H = 3; wid = XW'(W); hgt = YW'(H); dual = 1'b0;
    pulse_fs();
    send_gap(3, 100); send_line(8, 0);
    send_gap(2, 200); send_line(8, 1);
    send_gap(4, 300); send_line(8, 2);
    send_gap(2, 400); send_line(8, 3);      // R10 fourth row overruns height

    // dual channel
    dual = 1'b1;
    pulse_fs();
    send_gap(2, 500); send_line(8, 4);
    send_gap(1, 550); send_line(8, 5);
    send_gap(3, 560); send_line(6, 6);      // short row, R9 flagged at next gap
    send_gap(2, 600);
    pulse_fs();
    send_line(8, 7);

    // long row in single mode, then resync
    send_gap(2, 700);
    dual = 1'b0;
    send_line(10, 8);                       // R8 overrun
    send_gap(2, 800); send_line(8, 9);

    // odd width single row
    send_gap(2, 850);
    W = 5; wid = XW'(W);
    pulse_fs();
    send_line(5, 10);

    // full-format rows, R11
    send_gap(2, 900);
    W = 640; H = 480; wid = XW'(W); hgt = YW'(H); dual = 1'b1;
    pulse_fs();
    send_line(640, 11);
    send_gap(2, 950);
    dual = 1'b0;
    send_line(640, 12);

    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R2 R3 all expected pixels emitted", expq.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule